// File: doc/BRIEF.md
# Linear CCD Readout Timing Sequencer

This block generates every digital clock and strobe that a linear CCD and its correlated-double-sampling converter need for one complete image. While nothing is requested it keeps the sensor clean by running the transfer, serial and reset clocks together in repeating flush cycles. A start command is taken at the end of a flush cycle. The block then runs the first integration and a transfer into the serial register. After that it reads the line out one pixel at a time while the next line integrates. The line count, integration length, pixels per line and exposure-shortening length are sampled when the command is accepted.

Each pixel occupies five consecutive cycles. The block first resets the sense node, then takes the reference sample, then drives the two horizontal phases, and finally takes the data sample. The next transfer waits until both the readout of the current line and the integration of the next line have finished. The line period is therefore the longer of the two. A photodiode flush gate stays active for a programmable number of cycles at the start of each integration window, and this shortens the effective exposure.

Top module: `ccd_line_sequencer`

## Requirements
- R1: While idle, the block flushes: `xfer_o`, `h1_o` and `rst_clk_o` toggle every cycle, `h2_o` is the complement of `h1_o`, `pd_gate_o` is high and `busy_o` is low.
- R2: Idle time is divided into flush cycles of FLUSH_LEN clock cycles, counted from reset release or from the done cycle. A start is accepted at the end of the flush cycle in which it arrives, or at the end of a later one. `busy_o` is high from the cycle after the start pulse through the cycle of the last data strobe.
- R3: The first integration lasts exactly `integ_i` cycles after acceptance. During it `xfer_o` is low, `h1_o` toggles every cycle, `rst_clk_o` equals `h1_o` and `h2_o` is its complement.
- R4: Each transfer holds `xfer_o` high for XFER_LEN cycles while `h1_o`, `h2_o` and `rst_clk_o` stay low. Readout of the line begins in the cycle after the transfer.
- R5: Each pixel takes five cycles, with one output high per cycle in this order: `rst_clk_o`, `adc_ref_o`, `h1_o`, `h2_o`, `adc_dat_o`. The converter strobes never fire outside readout.
- R6: Every data strobe is preceded by a reference strobe exactly three cycles earlier.
- R7: `line_valid_o` is high for exactly 5·`pixels_i` cycles per line, and that window contains exactly `pixels_i` data strobes.
- R8: Integration of the next line starts with the readout of the current one. The next transfer starts max(5·`pixels_i`, `integ_i`) cycles after the readout started.
- R9: `pd_gate_o` is high for the first `shorten_i` cycles of each integration window and low for the rest of that window (`shorten_i` ≤ `integ_i`). It is low during transfers and high while idle.
- R10: `done_o` pulses for one cycle, the cycle after the last data strobe of the last line, and `busy_o` is low in that cycle.
- R11: A start pulse that arrives while `busy_o` is high has no effect. No extra strobes follow, and `busy_o` stays low after the done pulse.
- R12: `sol_o` is high with the data strobe of the first pixel of each line and low for every other pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle image capture request |
| lines_i | input | LINE_W | Lines per image, at least 1 |
| pixels_i | input | PIX_W | Pixels per line, at least 1 |
| integ_i | input | INT_W | Integration length in cycles, at least 1 |
| shorten_i | input | INT_W | Cycles of photodiode flush at the start of each integration window |
| xfer_o | output | 1 | Transfer clock enable |
| h1_o | output | 1 | Horizontal phase 1 enable |
| h2_o | output | 1 | Horizontal phase 2 enable |
| rst_clk_o | output | 1 | Sense-node reset clock enable |
| pd_gate_o | output | 1 | Photodiode flush gate |
| adc_ref_o | output | 1 | Reference-level sample strobe |
| adc_dat_o | output | 1 | Signal-level sample strobe |
| sol_o | output | 1 | First pixel of line marker |
| line_valid_o | output | 1 | Readout window of a line |
| busy_o | output | 1 | Capture pending or running |
| done_o | output | 1 | One-cycle capture complete pulse |

## Verification
The assertions assume that `lines_i`, `pixels_i` and `integ_i` are non-zero and stay stable from the start pulse until acceptance. They also assume that `shorten_i` does not exceed `integ_i` and that FLUSH_LEN is even, so the idle clocks toggle every cycle. The stimulus sets all parameter inputs before each start pulse and holds them until the done pulse. It picks only non-zero counts with a flush length no larger than the integration length, and it uses an even default flush length. Runs cover the two cases of the line period (readout longer than integration, and integration longer than readout), a one-pixel, one-line image, a start placed exactly on a flush boundary, and a start sent in the middle of a run.

// File: rtl/ccd_line_sequencer.sv
module ccd_line_sequencer #(
  parameter int LINE_W    = 12,
  parameter int PIX_W     = 13,
  parameter int INT_W     = 20,
  parameter int FLUSH_LEN = 8,
  parameter int XFER_LEN  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LINE_W-1:0] lines_i,
  input  logic [PIX_W-1:0]  pixels_i,
  input  logic [INT_W-1:0]  integ_i,
  input  logic [INT_W-1:0]  shorten_i,
  output logic              xfer_o,
  output logic              h1_o,
  output logic              h2_o,
  output logic              rst_clk_o,
  output logic              pd_gate_o,
  output logic              adc_ref_o,
  output logic              adc_dat_o,
  output logic              sol_o,
  output logic              line_valid_o,
  output logic              busy_o,
  output logic              done_o
);

  localparam int FW = $clog2(FLUSH_LEN + 1);
  localparam int XW = $clog2(XFER_LEN + 1);

  typedef enum logic [2:0] {S_FLUSH, S_INTEG, S_XFER, S_READ, S_WAIT} state_t;

  state_t            st;
  logic [FW-1:0]     fcnt;
  logic [XW-1:0]     xcnt;
  logic [2:0]        ph;
  logic [PIX_W-1:0]  pcnt;
  logic [INT_W-1:0]  icnt;
  logic [LINE_W-1:0] lrem;
  logic [PIX_W-1:0]  n_pix;
  logic [INT_W-1:0]  n_integ;
  logic [INT_W-1:0]  n_short;
  logic              pend;
  logic              done_q;

  logic [INT_W:0] inext;
  logic           integ_end, flush_end, take, last_pix, tg;

  assign inext     = {1'b0, icnt} + 1'b1;
  assign integ_end = inext >= {1'b0, n_integ};
  assign flush_end = fcnt == FW'(FLUSH_LEN - 1);
  assign take      = (st == S_FLUSH) && flush_end && (pend || start_i);
  assign last_pix  = (ph == 3'd4) && (pcnt == n_pix - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_FLUSH;
      fcnt    <= '0;
      xcnt    <= '0;
      ph      <= '0;
      pcnt    <= '0;
      icnt    <= '0;
      lrem    <= '0;
      n_pix   <= '0;
      n_integ <= '0;
      n_short <= '0;
      pend    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      pend   <= (st == S_FLUSH) && !take && (pend || start_i);
      case (st)
        S_FLUSH: begin
          fcnt <= flush_end ? '0 : fcnt + 1'b1;
          if (take) begin
            st      <= S_INTEG;
            icnt    <= '0;
            lrem    <= lines_i;
            n_pix   <= pixels_i;
            n_integ <= integ_i;
            n_short <= shorten_i;
          end
        end
        S_INTEG: begin
          icnt <= icnt + 1'b1;
          if (integ_end) begin
            st   <= S_XFER;
            xcnt <= '0;
          end
        end
        S_XFER: begin
          xcnt <= xcnt + 1'b1;
          if (xcnt == XW'(XFER_LEN - 1)) begin
            st   <= S_READ;
            ph   <= '0;
            pcnt <= '0;
            icnt <= '0;
          end
        end
        S_READ: begin
          if (icnt < n_integ) icnt <= icnt + 1'b1;
          ph <= (ph == 3'd4) ? 3'd0 : ph + 3'd1;
          if (ph == 3'd4) pcnt <= pcnt + 1'b1;
          if (last_pix) begin
            xcnt <= '0;
            if (lrem == LINE_W'(1)) begin
              st     <= S_FLUSH;
              fcnt   <= '0;
              done_q <= 1'b1;
            end else begin
              lrem <= lrem - 1'b1;
              st   <= integ_end ? S_XFER : S_WAIT;
            end
          end
        end
        S_WAIT: begin
          icnt <= icnt + 1'b1;
          if (integ_end) begin
            st   <= S_XFER;
            xcnt <= '0;
          end
        end
        default: st <= S_FLUSH;
      endcase
    end
  end

  assign tg           = (st == S_FLUSH) ? fcnt[0] : icnt[0];
  assign xfer_o       = (st == S_XFER) || ((st == S_FLUSH) && fcnt[0]);
  assign h1_o         = (st == S_READ) ? (ph == 3'd2) : (st != S_XFER) && tg;
  assign h2_o         = (st == S_READ) ? (ph == 3'd3) : (st != S_XFER) && !tg;
  assign rst_clk_o    = (st == S_READ) ? (ph == 3'd0) : (st != S_XFER) && tg;
  assign pd_gate_o    = (st == S_FLUSH) || ((st != S_XFER) && (icnt < n_short));
  assign adc_ref_o    = (st == S_READ) && (ph == 3'd1);
  assign adc_dat_o    = (st == S_READ) && (ph == 3'd4);
  assign sol_o        = adc_dat_o && (pcnt == '0);
  assign line_valid_o = (st == S_READ);
  assign busy_o       = pend || (st != S_FLUSH);
  assign done_o       = done_q;

  assert_idle_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> pd_gate_o);

  assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  assert_xfer_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_o && !pd_gate_o) |-> !(h1_o || h2_o || rst_clk_o));

  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid_o |-> ($countones({rst_clk_o, adc_ref_o, h1_o, h2_o, adc_dat_o}) == 1));

  assert_ref_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    adc_dat_o |-> $past(adc_ref_o, 3));

  assert_window_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_valid_o) |-> $past(adc_dat_o));

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(adc_dat_o)));

  assert_first_pixel_R12: assert property (@(posedge clk) disable iff (!rst_n)
    sol_o |-> !$past(line_valid_o, 5));

endmodule

// File: tb/test_ccd_line_sequencer.sv
module test_ccd_line_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int F = 8;
  localparam int X = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [11:0] lines_i = '0;
  logic [12:0] pixels_i = '0;
  logic [19:0] integ_i = '0;
  logic [19:0] shorten_i = '0;
  logic xfer_o, h1_o, h2_o, rst_clk_o, pd_gate_o, adc_ref_o, adc_dat_o;
  logic sol_o, line_valid_o, busy_o, done_o;

  ccd_line_sequencer #(.FLUSH_LEN(F), .XFER_LEN(X)) i_ccd_line_sequencer (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .lines_i(lines_i),
    .pixels_i(pixels_i), .integ_i(integ_i), .shorten_i(shorten_i),
    .xfer_o(xfer_o), .h1_o(h1_o), .h2_o(h2_o), .rst_clk_o(rst_clk_o),
    .pd_gate_o(pd_gate_o), .adc_ref_o(adc_ref_o), .adc_dat_o(adc_dat_o),
    .sol_o(sol_o), .line_valid_o(line_valid_o), .busy_o(busy_o), .done_o(done_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  int base = 0;
  int checks = 0;
  int errors = 0;
  int exp_cyc[$];
  bit exp_sol[$];
  logic [2:0] ref_hist = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: pops one expected data strobe per observed strobe
  always @(negedge clk) begin
    if (rst_n) begin
      if (adc_dat_o) begin
        if (exp_cyc.size() == 0) begin
          check(1'b0, "R11", "unexpected data strobe at cycle", cyc, -1);
        end else begin
          int e;
          bit s;
          e = exp_cyc.pop_front();
          s = exp_sol.pop_front();
          check(cyc == e, "R5", "data strobe cycle", cyc, e);
          check(ref_hist[2], "R6", "reference strobe three cycles earlier", ref_hist[2], 1);
          check(line_valid_o, "R7", "line_valid during data strobe", line_valid_o, 1);
          check(sol_o == s, "R12", "first-pixel marker", sol_o, s);
        end
      end
      ref_hist = {ref_hist[1:0], adc_ref_o};
    end
  end

  task automatic run(int nl, int np, int ni, int ns, int dly, bit align, bit poke);
    int xs[8];
    int rs[8];
    int c0, a, d, per;
    int m_busy, m_int, m_x1, m_x, m_pat, m_lv, m_log, m_done, lv_cnt, dat_cnt;
    bit prev_h1;
    repeat (dly) @(negedge clk);
    if (align) while (((cyc - base) % F) != F - 1) @(negedge clk);
    c0 = cyc;
    lines_i = 12'(nl); pixels_i = 13'(np); integ_i = 20'(ni); shorten_i = 20'(ns);
    start_i = 1'b1;
    a = c0;
    while (((a - base) % F) != F - 1) a++;
    per = (5 * np > ni) ? 5 * np : ni;
    xs[0] = a + ni + 1;
    for (int l = 0; l < nl; l++) begin
      rs[l] = xs[l] + X;
      if (l + 1 < nl) xs[l + 1] = rs[l] + per;
      for (int p = 0; p < np; p++) begin
        exp_cyc.push_back(rs[l] + 5 * p + 4);
        exp_sol.push_back(p == 0);
      end
    end
    d = rs[nl - 1] + 5 * np;
    m_busy = 0; m_int = 0; m_x1 = 0; m_x = 0; m_pat = 0; m_lv = 0; m_log = 0; m_done = 0;
    lv_cnt = 0; dat_cnt = 0; prev_h1 = h1_o;
    for (int n = c0 + 1; n <= d + 1; n++) begin
      bit xe, lve, loge;
      int k, ws;
      @(negedge clk);
      start_i = (poke && n == rs[0] + 2) ? 1'b1 : 1'b0;
      if (busy_o != (n <= d - 1)) m_busy++;
      if (done_o != (n == d)) m_done++;
      if (n > a && n < d) begin
        xe = 1'b0; lve = 1'b0; k = 0; ws = a + 1;
        for (int l = 0; l < nl; l++) begin
          if (n >= xs[l] && n < xs[l] + X) xe = 1'b1;
          if (n >= rs[l] && n < rs[l] + 5 * np) begin lve = 1'b1; k = (n - rs[l]) % 5; end
          if (n >= rs[l]) ws = rs[l];
        end
        loge = !xe && ((n - ws) < ns);
        if (n <= a + ni) begin
          if (xfer_o || h2_o == h1_o || rst_clk_o != h1_o || h1_o == prev_h1) m_int++;
        end
        if (xe && (!xfer_o || h1_o || h2_o || rst_clk_o)) begin
          if (n < xs[0] + X) m_x1++; else m_x++;
        end
        if (!xe && xfer_o) begin
          if (n < xs[0] + X) m_x1++; else m_x++;
        end
        if (lve) begin
          lv_cnt++;
          if (adc_dat_o) dat_cnt++;
          if (rst_clk_o != (k == 0) || adc_ref_o != (k == 1) || h1_o != (k == 2) ||
              h2_o != (k == 3) || adc_dat_o != (k == 4)) m_pat++;
        end else if (adc_ref_o || adc_dat_o) m_pat++;
        if (line_valid_o != lve) m_lv++;
        if (pd_gate_o != loge) m_log++;
      end
      prev_h1 = h1_o;
    end
    start_i = 1'b0;
    base = d;
    check(m_busy == 0, "R2", "busy mismatching cycles", m_busy, 0);
    check(m_int == 0, "R3", "first integration mismatching cycles", m_int, 0);
    check(m_x1 == 0, "R4", "first transfer mismatching cycles", m_x1, 0);
    check(m_x == 0, "R8", "later transfer placement mismatches", m_x, 0);
    check(m_pat == 0, "R5", "pixel pattern mismatching cycles", m_pat, 0);
    check(m_lv == 0, "R7", "line_valid mismatching cycles", m_lv, 0);
    check(lv_cnt == 5 * np * nl, "R7", "line_valid cycles", lv_cnt, 5 * np * nl);
    check(dat_cnt == np * nl, "R7", "data strobes inside windows", dat_cnt, np * nl);
    check(m_log == 0, "R9", "flush gate mismatching cycles", m_log, 0);
    check(m_done == 0, "R10", "done mismatching cycles", m_done, 0);
    check(exp_cyc.size() == 0, "R5", "missing data strobes", exp_cyc.size(), 0);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    base = cyc;
    check(!busy_o && !done_o && !line_valid_o && !adc_dat_o, "R1", "reset state busy/done/valid",
          {busy_o, done_o, line_valid_o, adc_dat_o}, 0);
    check(pd_gate_o, "R1", "reset state flush gate", pd_gate_o, 1);
    begin
      int bad;
      bit px, ph1;
      bad = 0; px = xfer_o; ph1 = h1_o;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (xfer_o == px || h1_o == ph1 || h2_o == h1_o || rst_clk_o != h1_o ||
            !pd_gate_o || busy_o) bad++;
        px = xfer_o; ph1 = h1_o;
      end
      check(bad == 0, "R1", "idle flush mismatching cycles", bad, 0);
    end
    run(3, 4, 30, 5, 3, 1'b0, 1'b0);
    run(2, 10, 12, 0, 2, 1'b1, 1'b0);
    run(1, 1, 1, 1, 5, 1'b0, 1'b0);
    run(2, 2040, 100, 50, 1, 1'b0, 1'b1);
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (busy_o || adc_dat_o || done_o) bad++;
      end
      check(bad == 0, "R11", "activity after ignored start", bad, 0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog run did not finish actual=%0d expected=%0d", cyc, 150000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule